// File: doc/BRIEF.md
# Serial ADC Scan Sequencer with Look-Ahead Channel Select

This block is an SPI master for a two-input, 12-bit serial converter whose input multiplexer runs one frame ahead of its data. Each 16-bit frame shifts out a command byte followed by eight zero bits. At the same time it shifts in the result of the conversion that the previous frame's command set up. The sequencer hides this lag. It sends a throw-away frame before a second-input-only scan and a return-to-default frame when scanning stops. In a two-input scan it orders the commands so that every captured word goes out tagged with the channel it really belongs to.

Software holds `scanEn` high for a scan session. The reference choice, the two-input enable and the scan mask are latched when the session opens. Each `trigger` pulse then runs one scan, which yields one or two samples on `sampleValid`/`sampleChan`/`sampleData`. A trigger that lands while frames are still in flight is dropped and sets a sticky `overrun` flag.

Top module: `adc_scan_seq`

## Requirements
- R1: The serial link runs in SPI mode 0. `spiSclk` is low whenever `spiCsN` is high. `spiMosi` changes only while `spiSclk` is low. `spiMiso` is captured on the rising edge. A frame is exactly 16 SCLK pulses, each half-period is CLK_DIV clock cycles, and so `spiCsN` stays low for 32*CLK_DIV cycles.
- R2: Between two frames, `spiCsN` stays high for at least one SCLK period (2*CLK_DIV cycles).
- R3: Each frame sends its command byte first, MSB first, followed by eight zero bits. Command bit 5 is 1 when `cfgExtRef` is 1. Bit 4 is 1 when two-input mode is on. Bit 3 is 1 to select input 1 and is only ever set in two-input mode. Bits 1:0 hold PWR_MODE (default 3). Bits 7:6 and bit 2 are 0.
- R4: A sample is the low 12 bits of the 16-bit received word, assembled MSB first, with no shift.
- R5: With `cfgDual`=0, `scanMask` is ignored. Every frame carries the input-0 command, and each trigger gives one sample with `sampleChan`=0.
- R6: With `cfgDual`=1 and mask 2'b11, a trigger runs two frames. The first carries the input-1 command and its result is output as channel 0. The second carries the input-0 command and its result is output as channel 1. Channel 0 is always presented first.
- R7: With `cfgDual`=1 and mask 2'b10, opening the session sends one input-1 frame that produces no sample. After that, each trigger runs one input-1 frame and gives one sample with `sampleChan`=1.
- R8: With `cfgDual`=1 and mask 2'b01 or 2'b00, each trigger runs one input-0 frame and gives one sample with `sampleChan`=0.
- R9: When `scanEn` falls, the scan in progress completes, then one input-0 frame is sent that produces no sample, and the block goes idle.
- R10: A trigger during the look-ahead frame or during scan frames starts no frame and sets `overrun`. `overrun` stays set until `overrunClr` is pulsed.
- R11: After reset, `spiCsN`=1, `spiSclk`=0, `sampleValid`=0 and `overrun`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgExtRef | input | 1 | 1 selects the external reference |
| cfgDual | input | 1 | Two-input mode enable |
| scanEn | input | 1 | Scan session enable |
| scanMask | input | 2 | Channels to scan (bit0 = input 0, bit1 = input 1) |
| trigger | input | 1 | Start one scan |
| overrunClr | input | 1 | Clears the overrun flag |
| spiSclk | output | 1 | Serial clock |
| spiCsN | output | 1 | Active-low chip select |
| spiMosi | output | 1 | Command data to the converter |
| spiMiso | input | 1 | Result data from the converter |
| sampleValid | output | 1 | One-cycle sample strobe |
| sampleChan | output | 1 | Channel of the sample |
| sampleData | output | 12 | Unsigned sample |
| overrun | output | 1 | Sticky dropped-trigger flag |

## Verification
The bench builds the block with CLK_DIV=2 and the default PWR_MODE of 3. A frame then takes about 70 cycles, so many sessions fit: back-to-back two-input frames, the look-ahead frame and the closing frame all occur many times in each run. A bench model of the converter keeps its own input selection, which each frame's command updates only once that frame has ended. It returns a random upper nibble above every 12-bit value, so a word attributed to the wrong channel or a wrong bit extraction shows up directly. Random sessions over reference, mode and mask are mixed with directed overrun and masking cases.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
  // Strobe bundle from control to datapath
  typedef struct packed {
    logic       start;
    logic [7:0] cmd;
  } dpCmd_t;

  typedef enum logic [2:0] {
    C_IDLE, C_PRIME, C_WAIT, C_FIRST, C_LAST, C_RESTORE
  } ctlState_t;

  typedef enum logic [1:0] {
    K_CH0, K_CH1, K_BOTH
  } scanKind_t;
endpackage

// File: rtl/adc_seq_dp.sv
`timescale 1ns/1ps
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int FRAME_W = 16,
  parameter int CMD_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCmd_t             ctl,
  output logic               sclk,
  output logic               csN,
  output logic               mosi,
  input  logic               miso,
  output logic               done,
  output logic               idle,
  output logic [FRAME_W-1:0] rxWord
);
  localparam int GAP   = 2 * CLK_DIV;
  localparam int CNT_W = $clog2(GAP + 1);
  localparam int BIT_W = $clog2(FRAME_W);

  typedef enum logic [1:0] {D_IDLE, D_SHIFT, D_GAP} dpState_t;

  dpState_t           st;
  logic [CNT_W-1:0]   divCnt;
  logic [BIT_W-1:0]   bitCnt;
  logic [FRAME_W-1:0] txShift;
  logic [FRAME_W-1:0] rxShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st      <= D_IDLE;
      divCnt  <= '0;
      bitCnt  <= '0;
      txShift <= '0;
      rxShift <= '0;
      sclk    <= 1'b0;
      csN     <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        D_IDLE: begin
          if (ctl.start) begin
            st      <= D_SHIFT;
            csN     <= 1'b0;
            sclk    <= 1'b0;
            divCnt  <= '0;
            bitCnt  <= '0;
            txShift <= {ctl.cmd, {(FRAME_W-CMD_W){1'b0}}};
          end
        end
        D_SHIFT: begin
          if (divCnt == CNT_W'(CLK_DIV - 1)) begin
            divCnt <= '0;
            if (!sclk) begin
              sclk    <= 1'b1;
              rxShift <= {rxShift[FRAME_W-2:0], miso};
            end else begin
              sclk <= 1'b0;
              if (bitCnt == BIT_W'(FRAME_W - 1)) begin
                csN <= 1'b1;
                st  <= D_GAP;
              end else begin
                bitCnt  <= bitCnt + 1'b1;
                txShift <= {txShift[FRAME_W-2:0], 1'b0};
              end
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        D_GAP: begin
          if (divCnt == CNT_W'(GAP - 1)) begin
            divCnt <= '0;
            st     <= D_IDLE;
            done   <= 1'b1;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: st <= D_IDLE;
      endcase
    end
  end

  assign mosi   = txShift[FRAME_W-1] & ~csN;
  assign idle   = (st == D_IDLE);
  assign rxWord = rxShift;

  // R1: clock parked low while deselected
  a_r1_sclk_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);
  // R1: data line holds while the clock is high
  a_r1_mosi_stable: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi));
  // R2: deselect lasts beyond a single cycle
  a_r2_cs_gap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |=> csN);
  // R1: control never starts a frame over a running one
  a_r1_start_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    ctl.start |-> (st == D_IDLE));
endmodule

// File: rtl/adc_seq_ctl.sv
`timescale 1ns/1ps
module adc_seq_ctl
  import adc_seq_pkg::*;
#(
  parameter int PWR_MODE = 3,
  parameter int DATA_W   = 12,
  parameter int FRAME_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgExtRef,
  input  logic               cfgDual,
  input  logic               scanEn,
  input  logic [1:0]         scanMask,
  input  logic               trigger,
  input  logic               overrunClr,
  input  logic               dpDone,
  input  logic               dpIdle,
  input  logic [FRAME_W-1:0] dpRx,
  output dpCmd_t             ctl,
  output logic               sampleValid,
  output logic               sampleChan,
  output logic [DATA_W-1:0]  sampleData,
  output logic               overrun
);
  ctlState_t st, nextSt;
  scanKind_t kindL, liveKind;
  logic      extRefL, dualL;

  function automatic logic [7:0] mkCmd(input logic ext, input logic dual, input logic ch1);
    mkCmd = {2'b00, ext, dual, ch1 & dual, 1'b0, 2'(PWR_MODE)};
  endfunction

  always_comb begin
    if (!cfgDual)                liveKind = K_CH0;
    else if (scanMask == 2'b11)  liveKind = K_BOTH;
    else if (scanMask == 2'b10)  liveKind = K_CH1;
    else                         liveKind = K_CH0;
  end

  always_comb begin
    ctl    = '0;
    nextSt = st;
    case (st)
      C_IDLE: begin
        if (scanEn && dpIdle) begin
          if (liveKind == K_CH1) begin
            ctl.start = 1'b1;
            ctl.cmd   = mkCmd(cfgExtRef, cfgDual, 1'b1);
            nextSt    = C_PRIME;
          end else begin
            nextSt = C_WAIT;
          end
        end
      end
      C_PRIME: if (dpDone) nextSt = C_WAIT;
      C_WAIT: begin
        if (!scanEn) begin
          ctl.start = 1'b1;
          ctl.cmd   = mkCmd(extRefL, dualL, 1'b0);
          nextSt    = C_RESTORE;
        end else if (trigger) begin
          ctl.start = 1'b1;
          ctl.cmd   = mkCmd(extRefL, dualL, kindL != K_CH0);
          nextSt    = (kindL == K_BOTH) ? C_FIRST : C_LAST;
        end
      end
      C_FIRST: begin
        if (dpDone) begin
          ctl.start = 1'b1;
          ctl.cmd   = mkCmd(extRefL, dualL, 1'b0);
          nextSt    = C_LAST;
        end
      end
      C_LAST:    if (dpDone) nextSt = C_WAIT;
      C_RESTORE: if (dpDone) nextSt = C_IDLE;
      default:   nextSt = C_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st          <= C_IDLE;
      kindL       <= K_CH0;
      extRefL     <= 1'b0;
      dualL       <= 1'b0;
      sampleValid <= 1'b0;
      sampleChan  <= 1'b0;
      sampleData  <= '0;
      overrun     <= 1'b0;
    end else begin
      st <= nextSt;
      if (st == C_IDLE) begin
        kindL   <= liveKind;
        extRefL <= cfgExtRef;
        dualL   <= cfgDual;
      end
      sampleValid <= dpDone && (st == C_FIRST || st == C_LAST);
      if (dpDone) begin
        sampleChan <= (st == C_LAST) && (kindL != K_CH0);
        sampleData <= dpRx[DATA_W-1:0];
      end
      if (trigger && (st == C_PRIME || st == C_FIRST || st == C_LAST))
        overrun <= 1'b1;
      else if (overrunClr)
        overrun <= 1'b0;
    end
  end

  // R10: flag holds until cleared
  a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !overrunClr) |=> overrun);
  // R10: a trigger mid-scan raises the flag
  a_r10_overrun_set: assert property (@(posedge clk) disable iff (!rstN)
    (trigger && st == C_FIRST) |=> overrun);
  // R6: samples are single-cycle strobes, a frame apart
  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);
  // R9: the closing frame yields no sample
  a_r9_restore_silent: assert property (@(posedge clk) disable iff (!rstN)
    (st == C_RESTORE && dpDone) |=> !sampleValid);
endmodule

// File: rtl/adc_scan_seq.sv
`timescale 1ns/1ps
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int CLK_DIV  = 4,
  parameter int PWR_MODE = 3,
  parameter int DATA_W   = 12,
  parameter int FRAME_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgExtRef,
  input  logic              cfgDual,
  input  logic              scanEn,
  input  logic [1:0]        scanMask,
  input  logic              trigger,
  input  logic              overrunClr,
  output logic              spiSclk,
  output logic              spiCsN,
  output logic              spiMosi,
  input  logic              spiMiso,
  output logic              sampleValid,
  output logic              sampleChan,
  output logic [DATA_W-1:0] sampleData,
  output logic              overrun
);
  dpCmd_t             ctl;
  logic               dpDone;
  logic               dpIdle;
  logic [FRAME_W-1:0] dpRx;

  adc_seq_ctl #(.PWR_MODE(PWR_MODE), .DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_ctl (
    .clk(clk), .rstN(rstN), .cfgExtRef(cfgExtRef), .cfgDual(cfgDual),
    .scanEn(scanEn), .scanMask(scanMask), .trigger(trigger),
    .overrunClr(overrunClr), .dpDone(dpDone), .dpIdle(dpIdle), .dpRx(dpRx),
    .ctl(ctl), .sampleValid(sampleValid), .sampleChan(sampleChan),
    .sampleData(sampleData), .overrun(overrun)
  );

  adc_seq_dp #(.CLK_DIV(CLK_DIV), .FRAME_W(FRAME_W), .CMD_W(8)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sclk(spiSclk), .csN(spiCsN),
    .mosi(spiMosi), .miso(spiMiso), .done(dpDone), .idle(dpIdle),
    .rxWord(dpRx)
  );
endmodule

// File: tb/adc_scan_seq_tb.sv
`timescale 1ns/1ps
module adc_scan_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgExtRef = 1'b0, cfgDual = 1'b0, scanEn = 1'b0;
  logic [1:0] scanMask = 2'b00;
  logic trigger = 1'b0, overrunClr = 1'b0;
  logic spiSclk, spiCsN, spiMosi, spiMiso;
  logic sampleValid, sampleChan, overrun;
  logic [11:0] sampleData;

  int checks = 0;
  int errors = 0;
  bit ready = 0;
  bit finished = 0;

  adc_scan_seq #(.CLK_DIV(DIV)) u_dut (
    .clk(clk), .rstN(rstN), .cfgExtRef(cfgExtRef), .cfgDual(cfgDual),
    .scanEn(scanEn), .scanMask(scanMask), .trigger(trigger),
    .overrunClr(overrunClr), .spiSclk(spiSclk), .spiCsN(spiCsN),
    .spiMosi(spiMosi), .spiMiso(spiMiso), .sampleValid(sampleValid),
    .sampleChan(sampleChan), .sampleData(sampleData), .overrun(overrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] cmdFor(input logic ext, input logic dual, input logic ch1);
    return {2'b00, ext, dual, ch1 & dual, 1'b0, 2'b11};
  endfunction

  // 0: input 0 only, 1: input 1 only, 2: both
  function automatic int kindOf(input logic dual, input logic [1:0] mask);
    if (!dual) return 0;
    if (mask == 2'b11) return 2;
    if (mask == 2'b10) return 1;
    return 0;
  endfunction

  // converter model
  logic [7:0]  expCmd[$];
  string       expTag[$];
  logic        expChan[$];
  logic        modelSel = 1'b0;
  logic [15:0] misoSh = '0;
  logic [15:0] mosiSh = '0;
  int          sclkCnt = 0;
  logic [11:0] frameVal = '0;
  logic        frameChan = 1'b0;
  logic [11:0] doneVal = '0;
  logic        doneChan = 1'b0;
  realtime     tFall = 0, tRise = 0;
  int          frameCnt = 0;

  assign spiMiso = misoSh[15];

  always @(negedge spiCsN) if (ready) begin
    tFall = $realtime;
    if (frameCnt > 0)
      check(tFall - tRise >= 2*DIV*CLK_PERIOD, "R2 cs gap ns", int'(tFall - tRise), 2*DIV*CLK_PERIOD);
    frameVal  = 12'($urandom);
    frameChan = modelSel;
    misoSh    = {4'($urandom | 1), frameVal};
    mosiSh    = '0;
    sclkCnt   = 0;
  end

  always @(negedge spiSclk) if (ready && !spiCsN) misoSh = {misoSh[14:0], 1'b0};

  always @(posedge spiSclk) if (ready) begin
    mosiSh = {mosiSh[14:0], spiMosi};
    sclkCnt++;
  end

  always @(posedge spiCsN) if (ready) begin
    tRise = $realtime;
    frameCnt++;
    check(sclkCnt == 16, "R1 sclk pulses", sclkCnt, 16);
    check(tRise - tFall == 32*DIV*CLK_PERIOD, "R1 cs low ns", int'(tRise - tFall), 32*DIV*CLK_PERIOD);
    check(mosiSh[7:0] == 8'h00, "R3 padding", mosiSh[7:0], 0);
    if (expCmd.size() == 0) begin
      check(1'b0, "R9 unexpected frame", mosiSh[15:8], 0);
    end else begin
      automatic logic [7:0] e = expCmd.pop_front();
      automatic string t = expTag.pop_front();
      check(mosiSh[15:8] == e, {t, " R3 command"}, mosiSh[15:8], e);
    end
    doneVal  = frameVal;
    doneChan = frameChan;
    modelSel = mosiSh[12] & mosiSh[11];
  end

  always @(negedge clk) if (ready && sampleValid) begin
    if (expChan.size() == 0) begin
      check(1'b0, "R9 unexpected sample", sampleChan, 0);
    end else begin
      automatic logic ec = expChan.pop_front();
      check(sampleChan == ec, "R6 sample channel order", sampleChan, ec);
    end
    check(sampleChan == doneChan, "R6 channel matches converter", sampleChan, doneChan);
    check(sampleData == doneVal, "R4 sample data", sampleData, doneVal);
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseTrig();
    @(negedge clk) trigger = 1'b1;
    @(negedge clk) trigger = 1'b0;
  endtask

  task automatic session(input logic ext, input logic dual, input logic [1:0] mask,
                         input int nTrig, input bit extra);
    automatic int k = kindOf(dual, mask);
    @(negedge clk);
    cfgExtRef = ext; cfgDual = dual; scanMask = mask; scanEn = 1'b1;
    if (k == 1) begin expCmd.push_back(cmdFor(ext, dual, 1)); expTag.push_back("R7 prime"); end
    waitClk(200);
    // changes after the session opened must have no effect
    scanMask = 2'($urandom); cfgExtRef = ~ext;
    for (int i = 0; i < nTrig; i++) begin
      if (k == 2) begin
        expCmd.push_back(cmdFor(ext, dual, 1)); expTag.push_back("R6 first");
        expCmd.push_back(cmdFor(ext, dual, 0)); expTag.push_back("R6 second");
        expChan.push_back(1'b0); expChan.push_back(1'b1);
      end else if (k == 1) begin
        expCmd.push_back(cmdFor(ext, dual, 1)); expTag.push_back("R7 scan");
        expChan.push_back(1'b1);
      end else begin
        expCmd.push_back(cmdFor(ext, dual, 0));
        expTag.push_back(dual ? "R8 scan" : "R5 scan");
        expChan.push_back(1'b0);
      end
      pulseTrig();
      if (extra) begin
        waitClk(20);
        pulseTrig();
        waitClk(2);
        check(overrun == 1'b1, "R10 overrun set", overrun, 1);
      end
      waitClk(250);
    end
    scanEn = 1'b0;
    expCmd.push_back(cmdFor(ext, dual, 0)); expTag.push_back("R9 restore");
    waitClk(150);
    check(expCmd.size() == 0, "R9 all frames seen", expCmd.size(), 0);
    check(expChan.size() == 0, "R9 all samples seen", expChan.size(), 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    waitClk(4);
    check(spiCsN == 1'b1, "R11 csN reset", spiCsN, 1);
    check(spiSclk == 1'b0, "R11 sclk reset", spiSclk, 0);
    check(sampleValid == 1'b0, "R11 valid reset", sampleValid, 0);
    check(overrun == 1'b0, "R11 overrun reset", overrun, 0);
    rstN = 1'b1;
    ready = 1;
    waitClk(5);
    // directed: single mode with mask ignored (R5)
    session(1'b1, 1'b0, 2'b10, 2, 0);
    session(1'b0, 1'b0, 2'b11, 1, 0);
    // directed: both inputs (R6), input 1 alone (R7), input 0 alone (R8)
    session(1'b0, 1'b1, 2'b11, 3, 0);
    session(1'b1, 1'b1, 2'b10, 3, 0);
    session(1'b0, 1'b1, 2'b01, 2, 0);
    session(1'b1, 1'b1, 2'b00, 1, 0);
    check(overrun == 1'b0, "R10 no spurious overrun", overrun, 0);
    // directed: overrun during a two-frame scan (R10)
    session(1'b0, 1'b1, 2'b11, 1, 1);
    waitClk(5);
    check(overrun == 1'b1, "R10 overrun sticky", overrun, 1);
    @(negedge clk) overrunClr = 1'b1;
    @(negedge clk) overrunClr = 1'b0;
    check(overrun == 1'b0, "R10 overrun cleared", overrun, 0);
    // random sessions
    for (int s = 0; s < 24; s++)
      session(1'($urandom), 1'($urandom), 2'($urandom), 1 + int'($urandom % 3), (s % 8) == 7);
    finished = 1;
  end

  initial begin
    int cyc = 0;
    while (!finished && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) check(1'b0, "watchdog expired", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule